// File: doc/BRIEF.md
# General-Purpose Up-Counting Timer with PWM Output

This block is a 32-bit up-counting timer driven by a small register interface. Software writes a control word to start the count, optionally slows the count through a power-of-two prescaler, and picks what happens when the count passes its maximum value. The counter can either reload from a load register and keep running, or stop and clear its run bit. A write of any value to the trigger register copies the load register into the counter. A compare unit raises a match event when the counter steps onto the value held in the match register.

Overflow and match events set sticky status bits. Software clears each bit by writing a 1 to it. An interrupt line goes high whenever a status bit and its enable bit are both set. Events can also drive a PWM pin, in one of two styles: the pin inverts on each chosen event, or it leaves its idle level for one clock per event. The idle level is programmable, so it also sets the polarity. The control word also holds a capture edge selector. The block only decodes that selector into two outputs, because the capture datapath itself is not part of it. Everything runs on a single clock, and a register write takes effect at the clock edge on which it is presented.

Top module: `gptimer_pwm`

## Requirements
- R1: After reset, every register reads zero and both `irq` and `pwm_out` are 0.
- R2: The registers sit at these byte offsets: status 0x18, interrupt enable 0x1C, control 0x24, counter 0x28, load 0x2C, trigger 0x30, match 0x38. Load, match and counter read back what was written. The control register keeps bits 12:0 and reads zero above them. Status and enable use bits 2:0. The trigger register reads zero.
- R3: While control bit 0 (run) is 1 and control bit 5 (prescaler enable) is 0, the counter rises by one every clock. While run is 0, the counter holds.
- R4: With control bit 5 set, the counter steps once every 2^(v+1) clocks, where v is control bits 4:2.
- R5: When the counter steps past 0xFFFFFFFF, status bit 1 (overflow) is set. If control bit 1 (auto-reload) is 1, the counter takes the load value. If it is 0, the counter becomes 0 and the run bit clears.
- R6: A write of any data to the trigger register loads the counter from the load register. A write to the counter register sets it directly. Either write overrides the count step in that cycle.
- R7: With control bit 6 (compare enable) set, a count step that lands on the match register value sets status bit 0 (match). With bit 6 clear, no match is flagged.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A control write that clears run while run is 1 also clears the overflow bit. A new event in the same cycle takes precedence over either clear. Status bit 2 (capture) is never set.
- R9: `irq` is 1 exactly when some status bit is set together with the matching bit of the interrupt enable register.
- R10: With control bit 12 set (toggle style), `pwm_out` inverts on each selected event. Control bits 11:10 choose the events: 00 none, 01 overflow only, 10 or 11 overflow and match. Selecting 00 returns the pin to its idle level.
- R11: With control bit 12 clear (pulse style), each selected event drives `pwm_out` away from its idle level for exactly the one following clock.
- R12: Control bit 7 gives the idle level of `pwm_out`: the pin equals bit 7 when no event is active.
- R13: Control bits 9:8 are decoded into capture edge outputs: 01 rising only, 10 falling only, 11 both, 00 neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 8 | Byte offset of the register being written |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte offset of the register being read |
| rd_data | output | 32 | Combinational read data for `rd_addr` |
| irq | output | 1 | Interrupt request |
| pwm_out | output | 1 | PWM pin |
| cap_on_rise | output | 1 | Capture on rising edge selected |
| cap_on_fall | output | 1 | Capture on falling edge selected |

## Verification
The assertions assume at most one register write per clock. They also assume that the write data is stable for the whole cycle in which `wr_en` is high. Properties about the count step, the auto-stop, the pulse return and the status clear are therefore conditioned on `wr_en` being low, or on the particular write not colliding with an event. The bench respects these assumptions by design. It drives every write for exactly one cycle, on the falling edge, through a single task. It exercises overflow and match only from register values it has placed itself, such as a counter preset a few steps below 0xFFFFFFFF, so that each event falls in a known cycle.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

  localparam int unsigned OFS_STAT  = 32'h18;
  localparam int unsigned OFS_IEN   = 32'h1C;
  localparam int unsigned OFS_CTL   = 32'h24;
  localparam int unsigned OFS_CNT   = 32'h28;
  localparam int unsigned OFS_LOAD  = 32'h2C;
  localparam int unsigned OFS_TRG   = 32'h30;
  localparam int unsigned OFS_MATCH = 32'h38;

  localparam int CTL_W = 13;
  localparam int ST_W  = 3;
  localparam int ST_MATCH = 0;
  localparam int ST_OVF   = 1;
  localparam int ST_CAP   = 2;

  // control word, most significant field first (bit 12 down to bit 0)
  typedef struct packed {
    logic       pwm_toggle;
    logic [1:0] pwm_sel;
    logic [1:0] cap_edge;
    logic       pwm_idle;
    logic       cmp_en;
    logic       pre_en;
    logic [2:0] pre_val;
    logic       auto_rl;
    logic       run;
  } ctrl_t;

  // does a counter event drive the pin under the given event selection
  function automatic logic pwm_fires(input logic [1:0] sel, input logic ovf, input logic mth);
    logic on_ovf;
    logic on_mth;
    on_ovf = (sel != 2'b00) && ovf;
    on_mth = sel[1] && mth;
    return on_ovf || on_mth;
  endfunction

endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pre_en,
  input  logic [PRE_W-1:0] pre_val,
  output logic             tick
);
  localparam int DIV_W = 1 << PRE_W;

  // last divider state before a tick: 2^(v+1) - 1
  function automatic logic [DIV_W-1:0] last_state(input logic [PRE_W-1:0] v);
    logic [DIV_W:0] span;
    span = (DIV_W + 1)'(1) << (int'(v) + 1);
    return DIV_W'(span - (DIV_W + 1)'(1));
  endfunction

  logic [DIV_W-1:0] div_q;
  logic             div_done;

  assign div_done = div_q >= last_state(pre_val);
  assign tick     = run && (!pre_en || div_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (!run || !pre_en || tick) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             auto_rl,
  input  logic             cmp_en,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             reload,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] match_val,
  output logic [CNT_W-1:0] count,
  output logic             ovf_evt,
  output logic             match_evt,
  output logic             auto_stop
);
  // value the counter takes on a step
  function automatic logic [CNT_W-1:0] step_value(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] ld,
                                                  input logic ar);
    if (cur == {CNT_W{1'b1}}) return ar ? ld : '0;
    return cur + CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] step_val;
  logic             at_max;
  logic             advance;

  assign at_max    = count_q == {CNT_W{1'b1}};
  assign step_val  = step_value(count_q, load_val, auto_rl);
  assign advance   = tick && !cnt_wr && !reload;
  assign ovf_evt   = advance && at_max;
  assign match_evt = advance && cmp_en && (step_val == match_val);
  assign auto_stop = ovf_evt && !auto_rl;
  assign count     = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (cnt_wr) begin
      count_q <= cnt_wdata;
    end else if (reload) begin
      count_q <= load_val;
    end else if (advance) begin
      count_q <= step_val;
    end
  end
endmodule

// File: rtl/gpt_status.sv
module gpt_status
  import gpt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] set_vec,
  input  logic [ST_W-1:0] w1c_vec,
  input  logic            ack_ovf,
  input  logic [ST_W-1:0] ien,
  output logic [ST_W-1:0] stat,
  output logic            irq
);
  logic [ST_W-1:0] stat_q;
  logic [ST_W-1:0] clr_vec;

  always_comb begin
    clr_vec = w1c_vec;
    if (ack_ovf) clr_vec[ST_OVF] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_vec) | set_vec;
    end
  end

  assign stat = stat_q;
  assign irq  = |(stat_q & ien);
endmodule

// File: rtl/gpt_pwm.sv
module gpt_pwm
  import gpt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       toggle_mode,
  input  logic       idle_lvl,
  input  logic [1:0] sel,
  input  logic       ovf_evt,
  input  logic       match_evt,
  output logic       pwm_ev,
  output logic       pwm_out
);
  logic tgl_q;
  logic pulse_q;

  assign pwm_ev = pwm_fires(sel, ovf_evt, match_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pwm_ev && !toggle_mode;
      if (sel == 2'b00) begin
        tgl_q <= 1'b0;
      end else if (toggle_mode && pwm_ev) begin
        tgl_q <= !tgl_q;
      end
    end
  end

  assign pwm_out = idle_lvl ^ (toggle_mode ? tgl_q : pulse_q);
endmodule

// File: rtl/gptimer_pwm.sv
module gptimer_pwm
  import gpt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int PRE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              irq,
  output logic              pwm_out,
  output logic              cap_on_rise,
  output logic              cap_on_fall
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] match_q;
  logic [ST_W-1:0]  ien_q;
  logic [ST_W-1:0]  stat;
  logic [CNT_W-1:0] count;

  // named internal events, also observed by the checker
  logic tick;
  logic ovf_evt;
  logic match_evt;
  logic auto_stop;
  logic pwm_ev;
  logic stop_ack;

  logic wr_stat, wr_ien, wr_ctl, wr_cnt, wr_load, wr_trg, wr_match;
  logic [ST_W-1:0] st_set;
  logic [ST_W-1:0] st_w1c;

  assign wr_stat  = wr_en && (wr_addr == ADDR_W'(OFS_STAT));
  assign wr_ien   = wr_en && (wr_addr == ADDR_W'(OFS_IEN));
  assign wr_ctl   = wr_en && (wr_addr == ADDR_W'(OFS_CTL));
  assign wr_cnt   = wr_en && (wr_addr == ADDR_W'(OFS_CNT));
  assign wr_load  = wr_en && (wr_addr == ADDR_W'(OFS_LOAD));
  assign wr_trg   = wr_en && (wr_addr == ADDR_W'(OFS_TRG));
  assign wr_match = wr_en && (wr_addr == ADDR_W'(OFS_MATCH));

  assign stop_ack = wr_ctl && ctrl_q.run && !wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      load_q  <= '0;
      match_q <= '0;
      ien_q   <= '0;
    end else begin
      if (wr_ctl) begin
        ctrl_q <= ctrl_t'(wr_data[CTL_W-1:0]);
      end else if (auto_stop) begin
        ctrl_q.run <= 1'b0;
      end
      if (wr_load)  load_q  <= wr_data;
      if (wr_match) match_q <= wr_data;
      if (wr_ien)   ien_q   <= wr_data[ST_W-1:0];
    end
  end

  gpt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q.run),
    .pre_en  (ctrl_q.pre_en),
    .pre_val (ctrl_q.pre_val),
    .tick    (tick)
  );

  gpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .auto_rl   (ctrl_q.auto_rl),
    .cmp_en    (ctrl_q.cmp_en),
    .cnt_wr    (wr_cnt),
    .cnt_wdata (wr_data),
    .reload    (wr_trg),
    .load_val  (load_q),
    .match_val (match_q),
    .count     (count),
    .ovf_evt   (ovf_evt),
    .match_evt (match_evt),
    .auto_stop (auto_stop)
  );

  always_comb begin
    st_set           = '0;
    st_set[ST_MATCH] = match_evt;
    st_set[ST_OVF]   = ovf_evt;
    st_set[ST_CAP]   = 1'b0;
    st_w1c           = wr_stat ? wr_data[ST_W-1:0] : '0;
  end

  gpt_status u_st (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (st_set),
    .w1c_vec (st_w1c),
    .ack_ovf (stop_ack),
    .ien     (ien_q),
    .stat    (stat),
    .irq     (irq)
  );

  gpt_pwm u_pwm (
    .clk         (clk),
    .rst_n       (rst_n),
    .toggle_mode (ctrl_q.pwm_toggle),
    .idle_lvl    (ctrl_q.pwm_idle),
    .sel         (ctrl_q.pwm_sel),
    .ovf_evt     (ovf_evt),
    .match_evt   (match_evt),
    .pwm_ev      (pwm_ev),
    .pwm_out     (pwm_out)
  );

  assign cap_on_rise = ctrl_q.cap_edge[0];
  assign cap_on_fall = ctrl_q.cap_edge[1];

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_W'(OFS_STAT):  rd_data = CNT_W'(stat);
      ADDR_W'(OFS_IEN):   rd_data = CNT_W'(ien_q);
      ADDR_W'(OFS_CTL):   rd_data = CNT_W'(ctrl_q);
      ADDR_W'(OFS_CNT):   rd_data = count;
      ADDR_W'(OFS_LOAD):  rd_data = load_q;
      ADDR_W'(OFS_MATCH): rd_data = match_q;
      default:            rd_data = '0;
    endcase
  end
endmodule

// File: rtl/gptimer_pwm_chk.sv
module gptimer_pwm_chk
  import gpt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_d0,
  input logic              tick,
  input logic              ovf_evt,
  input logic              match_evt,
  input logic              pwm_ev,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  load,
  input ctrl_t             ctrl,
  input logic [ST_W-1:0]   stat,
  input logic [ST_W-1:0]   ien,
  input logic              irq,
  input logic              pwm_out
);
  // R3: a plain step adds exactly one
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ovf_evt && !wr_en) |=> count == $past(count) + CNT_W'(1));

  // R3: stopped counter holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !wr_en) |=> $stable(count));

  // R5: overflow without auto-reload clears run and the count
  a_r5_auto_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !ctrl.auto_rl && !wr_en) |=> (!ctrl.run && count == '0));

  // R5: overflow with auto-reload takes the load value
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && ctrl.auto_rl && !wr_en) |=> count == $past(load));

  // R7: a match event leaves a sticky flag
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> stat[ST_MATCH]);

  // R8: write-one clears the match flag unless a match collides
  a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(OFS_STAT) && wr_d0 && !match_evt) |=> !stat[ST_MATCH]);

  // R8: the capture flag never rises
  a_r8_no_cap: assert property (@(posedge clk) disable iff (!rst_n) !stat[ST_CAP]);

  // R9: no enables, no interrupt
  a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);

  // R10: toggle style inverts the pin on a selected event
  a_r10_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.pwm_toggle && pwm_ev && !wr_en) |=> pwm_out != $past(pwm_out));

  // R11: a pulse lasts one clock when no further event follows
  a_r11_pulse_end: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.pwm_toggle && pwm_out != ctrl.pwm_idle && !pwm_ev && !wr_en) |=> pwm_out == ctrl.pwm_idle);
endmodule

bind gptimer_pwm gptimer_pwm_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_d0     (wr_data[0]),
  .tick      (tick),
  .ovf_evt   (ovf_evt),
  .match_evt (match_evt),
  .pwm_ev    (pwm_ev),
  .count     (count),
  .load      (load_q),
  .ctrl      (ctrl_q),
  .stat      (stat),
  .ien       (ien_q),
  .irq       (irq),
  .pwm_out   (pwm_out)
);

// File: tb/gptimer_pwm_test.sv
module gptimer_pwm_test;
  localparam logic [7:0] A_STAT = 8'h18, A_IEN = 8'h1C, A_CTL = 8'h24, A_CNT = 8'h28,
                         A_LOAD = 8'h2C, A_TRG = 8'h30, A_MATCH = 8'h38;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = A_CNT;
  logic [31:0] rd_data;
  logic        irq, pwm_out, cap_on_rise, cap_on_fall;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";
  bit rot_en = 1'b1;
  int rot_idx = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gptimer_pwm uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .pwm_out(pwm_out),
    .cap_on_rise(cap_on_rise), .cap_on_fall(cap_on_fall)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [31:0] m_cnt, m_load, m_match;
  bit [12:0] m_ctl;
  bit [2:0]  m_st, m_ien;
  int        m_div;
  bit        m_tgl, m_pulse;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_load = 0; m_match = 0; m_ctl = 0; m_st = 0; m_ien = 0;
      m_div = 0; m_tgl = 0; m_pulse = 0;
    end else begin
      automatic int period = m_ctl[5] ? (1 << (int'(m_ctl[4:2]) + 1)) : 1;
      automatic bit stepping = 0;
      automatic bit ov = 0, mt = 0, ev;
      automatic longint nx;
      automatic bit [31:0] c2 = m_cnt;
      automatic bit [12:0] k2 = m_ctl;
      automatic bit [2:0]  s2 = m_st;
      automatic bit wc = wr_en && wr_addr == A_CNT;
      automatic bit wt = wr_en && wr_addr == A_TRG;
      if (m_ctl[0]) begin
        if (m_div + 1 >= period) begin stepping = 1; m_div = 0; end
        else m_div = m_div + 1;
      end else m_div = 0;
      if (stepping && !wc && !wt) begin
        nx = longint'(m_cnt) + 1;
        if (nx > 64'hFFFF_FFFF) begin
          ov = 1;
          c2 = m_ctl[1] ? m_load : 32'd0;
        end else c2 = nx[31:0];
        if (m_ctl[6] && c2 == m_match) mt = 1;
      end
      if (wc) c2 = wr_data;
      if (wt) c2 = m_load;
      if (ov && !m_ctl[1]) k2[0] = 0;
      if (wr_en && wr_addr == A_CTL) k2 = wr_data[12:0];
      if (wr_en && wr_addr == A_STAT) s2 = s2 & ~wr_data[2:0];
      if (wr_en && wr_addr == A_CTL && m_ctl[0] && !wr_data[0]) s2[1] = 0;
      if (mt) s2[0] = 1;
      if (ov) s2[1] = 1;
      ev = (m_ctl[11:10] != 0 && ov) || (m_ctl[11] && mt);
      m_pulse = ev && !m_ctl[12];
      if (m_ctl[11:10] == 0) m_tgl = 0;
      else if (m_ctl[12] && ev) m_tgl = !m_tgl;
      if (wr_en && wr_addr == A_LOAD)  m_load  = wr_data;
      if (wr_en && wr_addr == A_MATCH) m_match = wr_data;
      if (wr_en && wr_addr == A_IEN)   m_ien   = wr_data[2:0];
      m_cnt = c2; m_ctl = k2; m_st = s2;
    end
  end

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      A_STAT:  return {29'd0, m_st};
      A_IEN:   return {29'd0, m_ien};
      A_CTL:   return {19'd0, m_ctl};
      A_CNT:   return m_cnt;
      A_LOAD:  return m_load;
      A_MATCH: return m_match;
      default: return 32'd0;
    endcase
  endfunction

  logic [7:0] rot_list [7] = '{A_STAT, A_IEN, A_CTL, A_CNT, A_LOAD, A_TRG, A_MATCH};

  // every-clock comparison against the model; rotates the read address
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, "rd_data", rd_data, model_read(rd_addr));
      check(cur_req, "irq", {31'd0, irq}, {31'd0, |(m_st & m_ien)});
      check(cur_req, "pwm_out", {31'd0, pwm_out},
            {31'd0, m_ctl[7] ^ (m_ctl[12] ? m_tgl : m_pulse)});
      check(cur_req, "cap", {30'd0, cap_on_fall, cap_on_rise}, {30'd0, m_ctl[9:8]});
      if (rot_en) begin
        rot_idx = (rot_idx + 1) % 7;
        rd_addr = rot_list[rot_idx];
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    #1;
    rot_en = 1'b0;
    rd_addr = a;
    #1;
    check(req, "peek", rd_data, exp);
    rot_en = 1'b1;
  endtask

  task automatic count_pin(input int cycles, output int highs, output int edges);
    logic prev;
    highs = 0; edges = 0;
    @(negedge clk); #1; prev = pwm_out;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk); #1;
      if (pwm_out) highs++;
      if (pwm_out != prev) edges++;
      prev = pwm_out;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int h, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cur_req = "R1";
    peek("R1", A_CTL, 0); peek("R1", A_CNT, 0); peek("R1", A_STAT, 0);
    check("R1", "pwm_out", {31'd0, pwm_out}, 0);
    check("R1", "irq", {31'd0, irq}, 0);

    // R2 register map
    cur_req = "R2";
    wr(A_LOAD, 32'h1234_5678); peek("R2", A_LOAD, 32'h1234_5678);
    wr(A_MATCH, 32'hCAFE_0001); peek("R2", A_MATCH, 32'hCAFE_0001);
    wr(A_CTL, 32'hFFFF_E080); peek("R2", A_CTL, 32'h0000_0080);
    cur_req = "R12";
    check("R12", "idle high", {31'd0, pwm_out}, 1);
    wr(A_TRG, 32'h0); peek("R2", A_TRG, 0);
    wr(A_CTL, 0);
    check("R12", "idle low", {31'd0, pwm_out}, 0);

    // R3 counting and hold
    cur_req = "R3";
    wr(A_CNT, 10); wr(A_CTL, 1);
    peek("R3", A_CNT, 11);
    wr(A_CTL, 0);
    peek("R3", A_CNT, 13);
    repeat (4) @(negedge clk);
    peek("R3", A_CNT, 13);

    // R4 prescaler
    cur_req = "R4";
    wr(A_CNT, 0); wr(A_CTL, 32'h21);            // v=0: every 2 clocks
    repeat (20) @(negedge clk);
    wr(A_CTL, 0); wr(A_CNT, 0); wr(A_CTL, 32'h29); // v=2: every 8 clocks
    repeat (40) @(negedge clk);
    wr(A_CTL, 32'h3D);                           // v=7: every 256 clocks
    repeat (600) @(negedge clk);
    wr(A_CTL, 0);

    // R5 overflow with and without auto-reload
    cur_req = "R5";
    wr(A_LOAD, 100); wr(A_CNT, 32'hFFFF_FFFE); wr(A_CTL, 3);
    peek("R5", A_CNT, 32'hFFFF_FFFF);
    peek("R5", A_CNT, 100);
    peek("R5", A_STAT, 2);
    wr(A_CTL, 0); wr(A_CNT, 32'hFFFF_FFFE); wr(A_CTL, 1);
    repeat (3) @(negedge clk);
    peek("R5", A_CTL, 0); peek("R5", A_CNT, 0); peek("R5", A_STAT, 2);

    // R8 clears and stop acknowledge
    cur_req = "R8";
    wr(A_CTL, 0); peek("R8", A_STAT, 2);       // already stopped: no ack
    wr(A_STAT, 1); peek("R8", A_STAT, 2);      // zero bit ignored
    wr(A_STAT, 2); peek("R8", A_STAT, 0);
    wr(A_LOAD, 32'hFFFF_FFF0); wr(A_CNT, 32'hFFFF_FFFE); wr(A_CTL, 3);
    repeat (3) @(negedge clk);
    wr(A_CTL, 0); peek("R8", A_STAT, 0);       // stop acks overflow

    // R6 trigger reload and direct counter write
    cur_req = "R6";
    wr(A_LOAD, 32'h55); wr(A_CNT, 32'h1000); wr(A_CTL, 1);
    wr(A_TRG, 32'hDEAD);
    peek("R6", A_CNT, 32'h56);
    wr(A_CNT, 32'h7777); peek("R6", A_CNT, 32'h7778);
    wr(A_CTL, 0);

    // R7 compare on and off
    cur_req = "R7";
    wr(A_CNT, 0); wr(A_MATCH, 5); wr(A_CTL, 32'h41);
    repeat (10) @(negedge clk);
    wr(A_CTL, 0); peek("R7", A_STAT, 1);
    wr(A_STAT, 1); wr(A_CNT, 0); wr(A_CTL, 1);
    repeat (10) @(negedge clk);
    wr(A_CTL, 0); peek("R7", A_STAT, 0);

    // R9 interrupt masking
    cur_req = "R9";
    wr(A_CNT, 0); wr(A_CTL, 32'h41); repeat (8) @(negedge clk); wr(A_CTL, 0);
    wr(A_IEN, 2); @(negedge clk); #1;
    check("R9", "irq masked", {31'd0, irq}, 0);
    wr(A_IEN, 1); @(negedge clk); #1;
    check("R9", "irq enabled", {31'd0, irq}, 1);
    wr(A_STAT, 7); @(negedge clk); #1;
    check("R9", "irq after clear", {31'd0, irq}, 0);
    wr(A_IEN, 3);

    // R10 toggle on overflow only, period 4
    cur_req = "R10";
    wr(A_LOAD, 32'hFFFF_FFFC); wr(A_MATCH, 32'hFFFF_FFFE); wr(A_CNT, 32'hFFFF_FFFC);
    wr(A_CTL, 32'h1403);
    repeat (3) @(negedge clk);
    count_pin(16, h, e);
    check("R10", "toggles overflow-only", e, 4);
    wr(A_CTL, 32'h1843);                         // overflow and match
    repeat (3) @(negedge clk);
    count_pin(16, h, e);
    check("R10", "toggles with match", e, 8);
    wr(A_CTL, 32'h1003);                         // none selected: idle
    repeat (2) @(negedge clk);
    count_pin(8, h, e);
    check("R10", "no events", e, 0);
    check("R10", "idle level", h, 0);

    // R11 pulse style, both polarities
    cur_req = "R11";
    wr(A_CTL, 32'h0403);
    repeat (3) @(negedge clk);
    count_pin(16, h, e);
    check("R11", "pulses high", h, 4);
    cur_req = "R12";
    wr(A_CTL, 32'h0483);
    repeat (3) @(negedge clk);
    count_pin(16, h, e);
    check("R12", "pulses low idle high", h, 12);
    wr(A_CTL, 0);

    // R13 capture edge decode
    cur_req = "R13";
    wr(A_CTL, 32'h100); @(negedge clk); #1;
    check("R13", "rise only", {30'd0, cap_on_fall, cap_on_rise}, 2'b01);
    wr(A_CTL, 32'h200); @(negedge clk); #1;
    check("R13", "fall only", {30'd0, cap_on_fall, cap_on_rise}, 2'b10);
    wr(A_CTL, 32'h300); @(negedge clk); #1;
    check("R13", "both", {30'd0, cap_on_fall, cap_on_rise}, 2'b11);
    wr(A_CTL, 0);
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule